// File: doc/BRIEF.md
# Serial interface reset and interrupt controller

This block owns the reset behaviour and the interrupt requests of a serial communication interface. It holds the interface control word, the clock control word and the status flags, and it applies four kinds of reset to them. A hardware reset and a software reset wipe everything. An individual reset, present while every pin-control bit is zero, holds only the status flags at their reset value. A stop reset also touches only the status flags.

The serial datapath reports events as single-cycle strobes: a character arrived (with its parity and framing error bits), the receive data was read, the status was read, transmit data was written, transmit data moved into the shifter, the shifter finished, the line went idle, and a timer tick. From these flags and the enable bits in the control word the block raises five level interrupt requests. It also gives the vector offset of the highest-priority request, with two words per vector. A receive with an error is reported on its own request line. That request persists until software reads the status and then reads the data.

Top module: `serif_rst_irq`

## Requirements
- R1: A hardware reset (`rst_n` low) or a software reset (`sw_rst` high at a clock edge) clears `ctrl_o` and `clkctl_o` to 0 and sets `stat_o` to 0x03. The status bit layout is: bit0 shifter empty, bit1 transmit buffer empty, bit2 receive full, bit3 idle, bit4 overrun, bit5 parity error, bit6 framing error.
- R2: While `pin_ctl` is all zeros (individual reset), `stat_o` is held at 0x03 from the next edge and every request is low. `ctrl_o` keeps its value and still accepts writes.
- R3: Any nonzero `pin_ctl` value makes the interface active, so that requests follow the flags and the enables.
- R4: While `stop_req` is high, every request is low at once and `stat_o` becomes 0x03 at the next edge. `ctrl_o` and `clkctl_o` keep their values.
- R5: A received character with no error sets bit2. With the receive enable (`ctrl_o` bit 11) set, it raises `irq_req[0]` with vector 0x14.
- R6: A received character with a parity or framing error sets bit5 or bit6. A character that arrives while bit2 is still set is an overrun and sets bit4. With bit 11 enabled, any of these three error bits raises `irq_req[1]` with vector 0x16, and `irq_req[0]` stays low.
- R7: A data read clears bit2. The error bits clear only on a data read that follows a status read made while an error was present. A data read alone leaves them set.
- R8: `irq_req[2]` (vector 0x18) is transmit buffer empty AND `ctrl_o` bit 12. `irq_req[3]` (vector 0x1A) is idle AND bit 10. `irq_req[4]` (vector 0x1C) is `tmr_tick` AND bit 13.
- R9: Requests are levels that stay high while their condition holds. `irq_any` is high when any request is high. `irq_vec` is 0x14 + 2*i, where i is the lowest active request index, and 0 when no request is active.
- R10: `tx_wr` clears bits 0 and 1, `tx_shift` sets bit1, `tx_end` sets bit0, and a received character clears bit3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset strobe |
| stop_req | input | 1 | Stop mode level |
| pin_ctl | input | 3 | Pin-control bits; all zero holds individual reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write data |
| clk_we | input | 1 | Clock control write strobe |
| clk_wdata | input | 16 | Clock control write data |
| rx_push | input | 1 | Character received |
| rx_perr | input | 1 | Parity error with rx_push |
| rx_ferr | input | 1 | Framing error with rx_push |
| data_rd | input | 1 | Receive data read strobe |
| stat_rd | input | 1 | Status read strobe |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_shift | input | 1 | Transmit data moved to shifter |
| tx_end | input | 1 | Shifter finished |
| idle_det | input | 1 | Idle line detected |
| tmr_tick | input | 1 | Timer event level |
| ctrl_o | output | 16 | Control word |
| clkctl_o | output | 16 | Clock control word |
| stat_o | output | 7 | Status flags |
| irq_req | output | 5 | Request lines: rx, rx error, tx, idle, timer |
| irq_any | output | 1 | Any request active |
| irq_vec | output | 7 | Vector offset of the winning request |

## Verification
A wrong reset scope shows up one edge after the reset cause: `stat_o` does not read 0x03, or a control word that should survive reads zero. A lost or early arming of the error clear is visible on `irq_req[1]`. That line either drops after a bare data read or stays high after the full sequence, and the check is made on the cycle after the read. Sweeping every enable mask against pending sources exposes any wrong bit position or priority slip in `irq_vec`, because both are combinational on registered state.

// File: rtl/serif_pkg.sv
package serif_pkg;
    typedef struct packed {
        logic frm;
        logic par;
        logic ovr;
        logic idle;
        logic rxf;
        logic txe_buf;
        logic txe_line;
    } stat_t;

    localparam stat_t STAT_RST = '{frm: 1'b0, par: 1'b0, ovr: 1'b0, idle: 1'b0,
                                   rxf: 1'b0, txe_buf: 1'b1, txe_line: 1'b1};
    localparam int NSRC = 5;
    localparam int EN_IDLE = 10;
    localparam int EN_RX   = 11;
    localparam int EN_TX   = 12;
    localparam int EN_TMR  = 13;
endpackage

// File: rtl/serif_status.sv
module serif_status
    import serif_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  rx_push,
    input  logic  rx_perr,
    input  logic  rx_ferr,
    input  logic  data_rd,
    input  logic  stat_rd,
    input  logic  tx_wr,
    input  logic  tx_shift,
    input  logic  tx_end,
    input  logic  idle_det,
    output stat_t stat_o
);
    typedef struct packed {
        stat_t st;
        logic  armed;
    } state_t;

    state_t s_d, s_q;
    logic   err_q;

    assign err_q = s_q.st.ovr | s_q.st.par | s_q.st.frm;

    always_comb begin
        s_d = s_q;
        if (stat_rd && err_q) s_d.armed = 1'b1;
        if (data_rd) begin
            s_d.st.rxf = 1'b0;
            if (s_q.armed) begin
                s_d.st.ovr = 1'b0;
                s_d.st.par = 1'b0;
                s_d.st.frm = 1'b0;
                s_d.armed  = 1'b0;
            end
        end
        if (rx_push) begin
            s_d.st.idle = 1'b0;
            if (s_q.st.rxf && !data_rd) begin
                s_d.st.ovr = 1'b1;
            end else begin
                s_d.st.rxf = 1'b1;
                s_d.st.par = s_d.st.par | rx_perr;
                s_d.st.frm = s_d.st.frm | rx_ferr;
            end
        end
        if (idle_det) s_d.st.idle = 1'b1;
        if (tx_wr) begin
            s_d.st.txe_buf  = 1'b0;
            s_d.st.txe_line = 1'b0;
        end
        if (tx_shift) s_d.st.txe_buf = 1'b1;
        if (tx_end)   s_d.st.txe_line = 1'b1;
        if (clr) begin
            s_d.st    = STAT_RST;
            s_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: STAT_RST, armed: 1'b0};
        else        s_q <= s_d;
    end

    assign stat_o = s_q.st;

    assert_clr_resets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (stat_o == STAT_RST));

    assert_err_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && err_q && data_rd && !s_q.armed) |=> (stat_o.ovr | stat_o.par | stat_o.frm));
endmodule

// File: rtl/serif_ctrl.sv
module serif_ctrl #(
    parameter int CTRL_W = 16,
    parameter int CLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              clk_we,
    input  logic [CLK_W-1:0]  clk_wdata,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CLK_W-1:0]  clkctl_o
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CLK_W-1:0]  clkc;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctrl_we) r_d.ctrl = ctrl_wdata;
        if (clk_we)  r_d.clkc = clk_wdata;
        if (sw_rst)  r_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl_o   = r_q.ctrl;
    assign clkctl_o = r_q.clkc;

    assert_swrst_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (ctrl_o == '0 && clkctl_o == '0));
endmodule

// File: rtl/serif_irq.sv
module serif_irq
    import serif_pkg::*;
#(
    parameter int CTRL_W   = 16,
    parameter int VEC_W    = 7,
    parameter int VEC_BASE = 'h14
) (
    input  stat_t             stat,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              tmr_tick,
    input  logic              run,
    output logic [NSRC-1:0]   req,
    output logic              irq_any,
    output logic [VEC_W-1:0]  irq_vec
);
    logic       err;
    logic [NSRC-1:0] cond;
    logic [NSRC-1:0] en;

    assign err  = stat.ovr | stat.par | stat.frm;
    assign cond = {tmr_tick, stat.idle, stat.txe_buf, err, stat.rxf & ~err};
    assign en   = {ctrl[EN_TMR], ctrl[EN_IDLE], ctrl[EN_TX], ctrl[EN_RX], ctrl[EN_RX]};

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign req[i] = run & cond[i] & en[i];
    end

    always_comb begin
        irq_vec = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) irq_vec = VEC_W'(VEC_BASE + 2 * i);
        end
    end

    assign irq_any = |req;

    always_comb begin
        if (irq_any) assert_vec_range_R9: assert (irq_vec >= VEC_W'(VEC_BASE) && irq_vec[0] == 1'b0);
    end
endmodule

// File: rtl/serif_rst_irq.sv
module serif_rst_irq
    import serif_pkg::*;
#(
    parameter int PIN_W    = 3,
    parameter int CTRL_W   = 16,
    parameter int CLK_W    = 16,
    parameter int VEC_W    = 7,
    parameter int VEC_BASE = 'h14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sw_rst,
    input  logic                   stop_req,
    input  logic [PIN_W-1:0]       pin_ctl,
    input  logic                   ctrl_we,
    input  logic [CTRL_W-1:0]      ctrl_wdata,
    input  logic                   clk_we,
    input  logic [CLK_W-1:0]       clk_wdata,
    input  logic                   rx_push,
    input  logic                   rx_perr,
    input  logic                   rx_ferr,
    input  logic                   data_rd,
    input  logic                   stat_rd,
    input  logic                   tx_wr,
    input  logic                   tx_shift,
    input  logic                   tx_end,
    input  logic                   idle_det,
    input  logic                   tmr_tick,
    output logic [CTRL_W-1:0]      ctrl_o,
    output logic [CLK_W-1:0]       clkctl_o,
    output logic [$bits(stat_t)-1:0] stat_o,
    output logic [NSRC-1:0]        irq_req,
    output logic                   irq_any,
    output logic [VEC_W-1:0]       irq_vec
);
    logic  active, run, stat_clr;
    stat_t stat;

    assign active   = |pin_ctl;
    assign run      = active & ~stop_req;
    assign stat_clr = sw_rst | ~active | stop_req;

    serif_ctrl #(.CTRL_W(CTRL_W), .CLK_W(CLK_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .clk_we(clk_we), .clk_wdata(clk_wdata),
        .ctrl_o(ctrl_o), .clkctl_o(clkctl_o)
    );

    serif_status u_stat (
        .clk(clk), .rst_n(rst_n), .clr(stat_clr),
        .rx_push(rx_push), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .data_rd(data_rd), .stat_rd(stat_rd),
        .tx_wr(tx_wr), .tx_shift(tx_shift), .tx_end(tx_end),
        .idle_det(idle_det), .stat_o(stat)
    );

    serif_irq #(.CTRL_W(CTRL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_irq (
        .stat(stat), .ctrl(ctrl_o), .tmr_tick(tmr_tick), .run(run),
        .req(irq_req), .irq_any(irq_any), .irq_vec(irq_vec)
    );

    assign stat_o = stat;

    assert_ctrl_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !ctrl_we && !sw_rst) |=> $stable(ctrl_o));

    assert_stop_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (stat_o == 7'h03));

    assert_rx_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_req[0] && irq_req[1]));
endmodule

// File: tb/serif_rst_irq_tb.sv
module serif_rst_irq_tb;
    logic        clk = 0, rst_n = 0, sw_rst = 0, stop_req = 0;
    logic [2:0]  pin_ctl = 0;
    logic        ctrl_we = 0, clk_we = 0;
    logic [15:0] ctrl_wdata = 0, clk_wdata = 0;
    logic        rx_push = 0, rx_perr = 0, rx_ferr = 0, data_rd = 0, stat_rd = 0;
    logic        tx_wr = 0, tx_shift = 0, tx_end = 0, idle_det = 0, tmr_tick = 0;
    logic [15:0] ctrl_o, clkctl_o;
    logic [6:0]  stat_o;
    logic [4:0]  irq_req;
    logic        irq_any;
    logic [6:0]  irq_vec;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    serif_rst_irq u_dut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .stop_req(stop_req), .pin_ctl(pin_ctl),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .clk_we(clk_we), .clk_wdata(clk_wdata),
        .rx_push(rx_push), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .data_rd(data_rd),
        .stat_rd(stat_rd), .tx_wr(tx_wr), .tx_shift(tx_shift), .tx_end(tx_end),
        .idle_det(idle_det), .tmr_tick(tmr_tick), .ctrl_o(ctrl_o), .clkctl_o(clkctl_o),
        .stat_o(stat_o), .irq_req(irq_req), .irq_any(irq_any), .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        ctrl_wdata = v; ctrl_we = 1; step(); ctrl_we = 0;
    endtask

    function automatic logic [6:0] vec_of(input logic [4:0] r);
        vec_of = 0;
        for (int i = 4; i >= 0; i--) if (r[i]) vec_of = 7'(8'h14 + 2 * i);
    endfunction

    task automatic chk_irq(input string tag, input logic [4:0] exp);
        chk({tag, " req"}, 32'(irq_req), 32'(exp));
        chk({tag, " vec"}, 32'(irq_vec), 32'(vec_of(exp)));
        chk({tag, " any"}, 32'(irq_any), 32'(|exp));
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        chk("R1 hw ctrl", 32'(ctrl_o), 0);
        chk("R1 hw clk", 32'(clkctl_o), 0);
        chk("R1 hw stat", 32'(stat_o), 32'h03);
        rst_n = 1; step();

        // R2: individual reset, writes still land, no requests
        wr_ctrl(16'h1000);
        chk("R2 ctrl write in reset", 32'(ctrl_o), 32'h1000);
        chk_irq("R2 masked", 5'b0);
        rx_push = 1; step(); rx_push = 0;
        chk("R2 stat held", 32'(stat_o), 32'h03);

        // R3: every nonzero pin pattern activates
        for (int p = 1; p < 8; p++) begin
            pin_ctl = 3'(p); step();
            chk_irq($sformatf("R3 pin %0d", p), 5'b00100);
            pin_ctl = 0; step();
            chk_irq("R2 back to reset", 5'b0);
        end
        pin_ctl = 3'b010;
        chk("R2 ctrl kept", 32'(ctrl_o), 32'h1000);

        // R5/R6/R7: sweep receive error patterns
        wr_ctrl(16'h0800);
        for (int e = 0; e < 4; e++) begin
            logic pe, fe;
            pe = e[0]; fe = e[1];
            rx_push = 1; rx_perr = pe; rx_ferr = fe; step();
            rx_push = 0; rx_perr = 0; rx_ferr = 0;
            chk($sformatf("R5 stat e%0d", e), 32'(stat_o), 32'(7'h07 | {fe, pe, 5'b0}));
            chk_irq($sformatf("R6 rx e%0d", e), (pe | fe) ? 5'b00010 : 5'b00001);
            data_rd = 1; step(); data_rd = 0;
            chk($sformatf("R7 data-only e%0d", e), 32'(stat_o), 32'(7'h03 | {fe, pe, 5'b0}));
            chk_irq($sformatf("R7 persist e%0d", e), (pe | fe) ? 5'b00010 : 5'b00000);
            stat_rd = 1; step(); stat_rd = 0;
            data_rd = 1; step(); data_rd = 0;
            chk($sformatf("R7 cleared e%0d", e), 32'(stat_o), 32'h03);
        end

        // R6: overrun
        rx_push = 1; step(); step(); rx_push = 0;
        chk("R6 overrun stat", 32'(stat_o), 32'h17);
        chk_irq("R6 overrun irq", 5'b00010);
        stat_rd = 1; step(); stat_rd = 0; data_rd = 1; step(); data_rd = 0;
        chk("R7 overrun clear", 32'(stat_o), 32'h03);

        // R10: transmit flag sequence
        tx_wr = 1; step(); tx_wr = 0;
        chk("R10 tx_wr", 32'(stat_o), 32'h00);
        tx_shift = 1; step(); tx_shift = 0;
        chk("R10 tx_shift", 32'(stat_o), 32'h02);
        tx_end = 1; step(); tx_end = 0;
        chk("R10 tx_end", 32'(stat_o), 32'h03);

        // R8/R9: sweep enable masks against all sources pending
        rx_push = 1; step(); rx_push = 0;
        idle_det = 1; step(); idle_det = 0;
        chk("R10 stat pend", 32'(stat_o), 32'h0F);
        tmr_tick = 1;
        for (int m = 0; m < 16; m++) begin
            logic [4:0] exp;
            logic [15:0] w;
            w = 16'(m) << 10;
            wr_ctrl(w);
            exp = {w[13], w[10], w[12], 1'b0, w[11]};
            chk_irq($sformatf("R8 mask %0h", m), exp);
        end
        step();
        chk_irq("R9 level hold", 5'b11101);
        tmr_tick = 0; #1;
        chk_irq("R8 timer drop", 5'b01101);
        rx_push = 1; step(); rx_push = 0;
        chk_irq("R10 idle cleared by rx", 5'b00110);

        // R4: stop
        clk_wdata = 16'h1234; clk_we = 1; step(); clk_we = 0;
        stop_req = 1; #1;
        chk_irq("R4 stop masks", 5'b0);
        step();
        chk("R4 stat", 32'(stat_o), 32'h03);
        chk("R4 ctrl", 32'(ctrl_o), 32'h3C00);
        chk("R4 clk", 32'(clkctl_o), 32'h1234);
        stop_req = 0; step();
        chk_irq("R4 resume", 5'b00100);

        // R1: software reset
        sw_rst = 1; step(); sw_rst = 0;
        chk("R1 sw ctrl", 32'(ctrl_o), 0);
        chk("R1 sw clk", 32'(clkctl_o), 0);
        chk("R1 sw stat", 32'(stat_o), 32'h03);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule